// File: doc/BRIEF.md
# Dual-Channel Bus-Master DMA Register File

This block holds the host-visible registers of a two-channel bus-master DMA controller for a disk interface. A byte-wide host port reaches a 16-byte space split into two 8-byte channel windows. Each channel has a command byte, a status byte, a timing byte and a 32-bit descriptor table pointer. Both channels also share one mode byte. The mode byte records the level of each channel's drive interrupt request. It also holds a per-channel block bit, and together these form one combined host interrupt.

The status byte mixes several kinds of bits. Some are plain read-write, one mirrors the command start bit, and two are write-one-to-clear. The two write-one-to-clear bits are set by hardware: an error pulse sets one, and a rising interrupt request sets the other. The DMA engine, descriptor fetching and the drive task-file ports sit elsewhere and connect through the plain register outputs and the request inputs. The host port is a simple strobe interface with no back-pressure: a write takes effect at the clock edge that samples it, and a read returns data one cycle after its strobe.

Top module: `ide_bm_regs`

## Requirements
- R1: After reset, every byte of the 16-byte space reads 0x00 and `host_irq` is low.
- R2: Address bit 3 selects the channel, so channel 0 sits at 0-7 and channel 1 at 8-15. Within a window, offset 0 is command, 1 is the shared mode byte, 2 is status, 3 is timing, and 4-7 are the descriptor pointer bytes, least significant first.
- R3: A command write stores only bit 0 (start) and bit 3 (direction); the other command bits read 0. Status bit 0 always reads as that channel's command bit 0, and a status write does not change it.
- R4: Each channel has its own timing byte at offset 3, and a write stores all 8 bits into the timing byte of the addressed channel only.
- R5: A mode write through either window changes only bits 4 and 5. Bits 2 and 3 keep their value, and bits 0, 1, 6 and 7 read 0.
- R6: Mode bit 2+c equals the level of `irq_req[c]` sampled at the previous clock edge.
- R7: `host_irq` is high exactly when (mode bit 2 and not bit 4) or (mode bit 3 and not bit 5), evaluated from the current mode byte.
- R8: A status write loads bits 5 and 6 from the data; status bits 3, 4 and 7 always read 0.
- R9: Status bits 1 and 2 are cleared by writing 1 to them, and writing 0 leaves them unchanged. A pulse on `err_evt[c]` sets bit 1, and a rising edge of `irq_req[c]` sets bit 2. When a set and a clear hit the same bit in the same cycle, the set wins.
- R10: Pointer bytes are written one at a time, and bits 1:0 of the pointer always read 0.
- R11: Read data appears on `reg_rdata` one cycle after `reg_rd` and then holds until the next read; reads change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_addr | input | 4 | Byte address within the block |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 8 | Write data |
| reg_rd | input | 1 | Read strobe |
| reg_rdata | output | 8 | Read data, one cycle after the strobe |
| irq_req | input | 2 | Per-channel interrupt request level from the drive side |
| err_evt | input | 2 | Per-channel error pulse, sets status bit 1 |
| host_irq | output | 1 | Combined host interrupt |
| chan_cmd | output | 16 | Command byte per channel (channel 1 in the upper byte) |
| chan_tim | output | 16 | Timing byte per channel |
| chan_ptr | output | 64 | Descriptor pointer per channel |

## Verification
The hardest case to reach is a status write that clears a bit in the same cycle hardware sets it. This needs an `irq_req` rising edge or an `err_evt` pulse to line up exactly with a one-to-clear write to the same channel. The bench forces this collision with directed steps. The random phase toggles requests rarely and writes status often, so such coincidences keep recurring, and a cycle-accurate model in the bench predicts each one.

// File: rtl/ide_bm_pkg.sv
package ide_bm_pkg;
  localparam int NCH = 2;
  localparam int AW = 4;
  localparam int PTR_W = 32;
  localparam int PTR_BYTES = PTR_W / 8;
  localparam logic [7:0] CMD_KEEP = 8'h09;
  localparam int FLAG_LSB = 2;
  localparam int BLK_LSB = 4;

  typedef enum logic [2:0] {
    OFF_CMD  = 3'd0,
    OFF_MODE = 3'd1,
    OFF_STS  = 3'd2,
    OFF_TIM  = 3'd3,
    OFF_P0   = 3'd4,
    OFF_P1   = 3'd5,
    OFF_P2   = 3'd6,
    OFF_P3   = 3'd7
  } reg_off_e;
endpackage

// File: rtl/ide_bm_mode.sv
module ide_bm_mode
  import ide_bm_pkg::*;
(
  input  logic           clk,
  input  logic           rst_n,
  input  logic           wr_mode,
  input  logic [7:0]     wdata,
  input  logic [NCH-1:0] irq_req,
  output logic [7:0]     mode_o,
  output logic [NCH-1:0] irq_rise,
  output logic           host_irq
);
  logic [NCH-1:0] flag_q;
  logic [NCH-1:0] blk_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flag_q <= '0;
      blk_q  <= '0;
    end else begin
      flag_q <= irq_req;
      if (wr_mode) blk_q <= wdata[BLK_LSB +: NCH];
    end
  end

  assign irq_rise = irq_req & ~flag_q;

  always_comb begin
    mode_o = '0;
    mode_o[FLAG_LSB +: NCH] = flag_q;
    mode_o[BLK_LSB +: NCH]  = blk_q;
  end

  assign host_irq = |(flag_q & ~blk_q);
endmodule

// File: rtl/ide_bm_chan.sv
module ide_bm_chan
  import ide_bm_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_cmd,
  input  logic                 wr_sts,
  input  logic                 wr_tim,
  input  logic [PTR_BYTES-1:0] wr_ptr,
  input  logic [7:0]           wdata,
  input  logic                 irq_rise,
  input  logic                 err_evt,
  output logic [7:0]           cmd_o,
  output logic [7:0]           sts_o,
  output logic [7:0]           tim_o,
  output logic [PTR_W-1:0]     ptr_o
);
  logic [7:0] cmd_q, tim_q;
  logic       err_q, done_q, s5_q, s6_q;
  logic [PTR_W-1:0] ptr_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmd_q  <= '0;
      tim_q  <= '0;
      err_q  <= 1'b0;
      done_q <= 1'b0;
      s5_q   <= 1'b0;
      s6_q   <= 1'b0;
    end else begin
      if (wr_cmd) cmd_q <= wdata & CMD_KEEP;
      if (wr_tim) tim_q <= wdata;
      if (wr_sts) begin
        s5_q <= wdata[5];
        s6_q <= wdata[6];
      end
      err_q  <= (err_q  & ~(wr_sts & wdata[1])) | err_evt;
      done_q <= (done_q & ~(wr_sts & wdata[2])) | irq_rise;
    end
  end

  for (genvar b = 0; b < PTR_BYTES; b++) begin : g_ptr
    logic [7:0] keep;
    if (b == 0) begin : g_lo
      assign keep = 8'hFC;
    end else begin : g_hi
      assign keep = 8'hFF;
    end
    always_ff @(posedge clk) begin
      if (!rst_n) ptr_q[b*8 +: 8] <= '0;
      else if (wr_ptr[b]) ptr_q[b*8 +: 8] <= wdata & keep;
    end
  end

  assign cmd_o = cmd_q;
  assign tim_o = tim_q;
  assign ptr_o = ptr_q;
  assign sts_o = {1'b0, s6_q, s5_q, 2'b00, done_q, err_q, cmd_q[0]};
endmodule

// File: rtl/ide_bm_regs.sv
module ide_bm_regs
  import ide_bm_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [3:0]        reg_addr,
  input  logic              reg_wr,
  input  logic [7:0]        reg_wdata,
  input  logic              reg_rd,
  output logic [7:0]        reg_rdata,
  input  logic [1:0]        irq_req,
  input  logic [1:0]        err_evt,
  output logic              host_irq,
  output logic [15:0]       chan_cmd,
  output logic [15:0]       chan_tim,
  output logic [63:0]       chan_ptr
);
  reg_off_e  off;
  logic      sel_ch;
  logic [7:0] mode_q;
  logic [NCH-1:0] irq_rise;
  logic [NCH-1:0][7:0] sts_q, cmd_q, tim_q;
  logic [NCH-1:0][PTR_W-1:0] ptr_q;
  logic [7:0] rd_mux, rdata_q;

  assign off    = reg_off_e'(reg_addr[2:0]);
  assign sel_ch = reg_addr[AW-1];

  ide_bm_mode u_mode (
    .clk(clk), .rst_n(rst_n),
    .wr_mode(reg_wr && off == OFF_MODE),
    .wdata(reg_wdata), .irq_req(irq_req),
    .mode_o(mode_q), .irq_rise(irq_rise), .host_irq(host_irq)
  );

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    logic hit;
    logic [PTR_BYTES-1:0] wp;
    assign hit = reg_wr && (sel_ch == 1'(c));
    for (genvar b = 0; b < PTR_BYTES; b++) begin : g_wp
      assign wp[b] = hit && (reg_addr[2:0] == 3'(OFF_P0 + b));
    end
    ide_bm_chan u_chan (
      .clk(clk), .rst_n(rst_n),
      .wr_cmd(hit && off == OFF_CMD),
      .wr_sts(hit && off == OFF_STS),
      .wr_tim(hit && off == OFF_TIM),
      .wr_ptr(wp), .wdata(reg_wdata),
      .irq_rise(irq_rise[c]), .err_evt(err_evt[c]),
      .cmd_o(cmd_q[c]), .sts_o(sts_q[c]), .tim_o(tim_q[c]), .ptr_o(ptr_q[c])
    );
  end

  always_comb begin
    unique case (off)
      OFF_CMD:  rd_mux = cmd_q[sel_ch];
      OFF_MODE: rd_mux = mode_q;
      OFF_STS:  rd_mux = sts_q[sel_ch];
      OFF_TIM:  rd_mux = tim_q[sel_ch];
      OFF_P0:   rd_mux = ptr_q[sel_ch][7:0];
      OFF_P1:   rd_mux = ptr_q[sel_ch][15:8];
      OFF_P2:   rd_mux = ptr_q[sel_ch][23:16];
      default:  rd_mux = ptr_q[sel_ch][31:24];
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) rdata_q <= '0;
    else if (reg_rd) rdata_q <= rd_mux;
  end

  assign reg_rdata = rdata_q;
  assign chan_cmd  = cmd_q;
  assign chan_tim  = tim_q;
  assign chan_ptr  = ptr_q;
endmodule

// File: rtl/ide_bm_chk.sv
module ide_bm_chk (
  input logic             clk,
  input logic             rst_n,
  input logic             reg_rd,
  input logic [7:0]       reg_rdata,
  input logic             reg_wr,
  input logic [3:0]       reg_addr,
  input logic [1:0]       irq_req,
  input logic [1:0]       err_evt,
  input logic             host_irq,
  input logic [7:0]       mode_q,
  input logic [1:0][7:0]  sts_q
);
  a_r6_flag_follows: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req[0] |=> mode_q[2]);
  a_r5_blk_stable: assert property (@(posedge clk) disable iff (!rst_n)
    !(reg_wr && reg_addr[2:0] == 3'd1) |=> $stable(mode_q[5:4]));
  a_r7_all_blocked: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q[4] && mode_q[5]) |-> !host_irq);
  a_r7_ch1_open: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q[3] && !mode_q[5]) |-> host_irq);
  a_r9_err_sets: assert property (@(posedge clk) disable iff (!rst_n)
    err_evt[1] |=> sts_q[1][1]);
  a_r11_rdata_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !reg_rd |=> $stable(reg_rdata));
endmodule

bind ide_bm_regs ide_bm_chk u_chk (
  .clk(clk), .rst_n(rst_n), .reg_rd(reg_rd), .reg_rdata(reg_rdata),
  .reg_wr(reg_wr), .reg_addr(reg_addr), .irq_req(irq_req),
  .err_evt(err_evt), .host_irq(host_irq), .mode_q(mode_q), .sts_q(sts_q)
);

// File: tb/tb_ide_bm_regs.sv
module tb_ide_bm_regs;
  logic clk = 0, rst_n = 0;
  logic [3:0] reg_addr = 0;
  logic reg_wr = 0, reg_rd = 0;
  logic [7:0] reg_wdata = 0, reg_rdata;
  logic [1:0] irq_req = 0, err_evt = 0;
  logic host_irq;
  logic [15:0] chan_cmd, chan_tim;
  logic [63:0] chan_ptr;

  always #2.5 clk = ~clk;

  ide_bm_regs dut (.*);

  int n_vec = 0, n_bad = 0, cyc = 0;
  logic [7:0] m_cmd[2], m_tim[2];
  logic [31:0] m_ptr[2];
  logic m_s1[2], m_s2[2], m_s5[2], m_s6[2], m_blk[2], m_flag[2];
  logic [7:0] last_rd;

  task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [7:0] m_rd(logic [3:0] a);
    int c = a[3];
    case (a[2:0])
      3'd0: return m_cmd[c];
      3'd1: return {2'b00, m_blk[1], m_blk[0], m_flag[1], m_flag[0], 2'b00};
      3'd2: return {1'b0, m_s6[c], m_s5[c], 2'b00, m_s2[c], m_s1[c], m_cmd[c][0]};
      3'd3: return m_tim[c];
      default: return m_ptr[c][a[1:0]*8 +: 8];
    endcase
  endfunction

  function automatic string tag_of(logic [3:0] a);
    case (a[2:0])
      3'd0: return "R3";
      3'd1: return "R5/R6";
      3'd2: return "R8/R9";
      3'd3: return "R4";
      default: return "R10";
    endcase
  endfunction

  task automatic m_reset();
    for (int c = 0; c < 2; c++) begin
      m_cmd[c] = 0; m_tim[c] = 0; m_ptr[c] = 0;
      m_s1[c] = 0; m_s2[c] = 0; m_s5[c] = 0; m_s6[c] = 0;
      m_blk[c] = 0; m_flag[c] = 0;
    end
    last_rd = 0;
  endtask

  task automatic step(bit wr, bit rd, logic [3:0] a, logic [7:0] d,
                      logic [1:0] irq, logic [1:0] err);
    logic [7:0] exp_r;
    logic rise[2];
    logic clr1, clr2;
    int ch;
    @(negedge clk);
    reg_wr = wr; reg_rd = rd; reg_addr = a; reg_wdata = d;
    irq_req = irq; err_evt = err;
    exp_r = m_rd(a);
    @(posedge clk);
    ch = a[3];
    for (int c = 0; c < 2; c++) rise[c] = irq[c] & ~m_flag[c];
    clr1 = 0; clr2 = 0;
    if (wr) begin
      case (a[2:0])
        3'd0: m_cmd[ch] = d & 8'h09;
        3'd1: begin m_blk[0] = d[4]; m_blk[1] = d[5]; end
        3'd2: begin m_s5[ch] = d[5]; m_s6[ch] = d[6]; clr1 = d[1]; clr2 = d[2]; end
        3'd3: m_tim[ch] = d;
        default: m_ptr[ch][a[1:0]*8 +: 8] = (a[1:0] == 0) ? (d & 8'hFC) : d;
      endcase
    end
    for (int c = 0; c < 2; c++) begin
      m_s1[c] = (m_s1[c] & ~(clr1 && c == ch)) | err[c];
      m_s2[c] = (m_s2[c] & ~(clr2 && c == ch)) | rise[c];
      m_flag[c] = irq[c];
    end
    #1;
    if (rd) begin
      chk({tag_of(a), " R2 R11 read"}, reg_rdata, exp_r);
      last_rd = exp_r;
    end else chk("R11 hold", reg_rdata, last_rd);
    chk("R7 host_irq", {7'd0, host_irq},
        {7'd0, (m_flag[0] & ~m_blk[0]) | (m_flag[1] & ~m_blk[1])});
  endtask

  initial begin : watchdog
    while (cyc < 100000) begin @(posedge clk); cyc++; end
    n_bad++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin : main
    logic [1:0] irq;
    m_reset();
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1;
    // R1: every byte reads zero after reset
    for (int a = 0; a < 16; a++) step(0, 1, 4'(a), 8'h00, 2'b00, 2'b00);
    chk("R1 host_irq", {7'd0, host_irq}, 8'd0);
    // R3/R4/R10 directed: distinct timing per channel, pointer masking
    step(1, 0, 4'd3, 8'hA5, 0, 0);
    step(1, 0, 4'd11, 8'h3C, 0, 0);
    step(1, 0, 4'd12, 8'hFF, 0, 0);
    step(1, 0, 4'd8, 8'hFF, 0, 0);
    step(0, 1, 4'd3, 0, 0, 0);
    step(0, 1, 4'd11, 0, 0, 0);
    step(0, 1, 4'd12, 0, 0, 0);
    step(0, 1, 4'd10, 0, 0, 0);
    // R5: mode write via ch1 window with flags present
    step(1, 0, 4'd9, 8'hFF, 2'b01, 0);
    step(0, 1, 4'd1, 0, 2'b01, 0);
    step(1, 0, 4'd1, 8'h00, 2'b01, 0);
    // R9 collision: rising irq ch1 and W1C write same cycle; set wins
    step(1, 0, 4'd10, 8'h06, 2'b11, 2'b10);
    step(0, 1, 4'd10, 0, 2'b11, 0);
    step(1, 0, 4'd10, 8'h06, 2'b11, 0);
    step(0, 1, 4'd10, 0, 2'b00, 0);
    // random phase
    irq = 0;
    void'($urandom(32'd1234));
    for (int i = 0; i < 4000; i++) begin
      if ($urandom_range(7) == 0) irq[$urandom_range(1)] ^= 1'b1;
      step($urandom_range(1), $urandom_range(9) < 6, 4'($urandom_range(15)),
           8'($urandom), irq, ($urandom_range(15) == 0) ? 2'($urandom) : 2'b00);
    end
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule